// File: doc/BRIEF.md
# Weekly Minute-Resolution Alarm Comparator

This block compares the running wall-clock time against a programmed alarm and raises an interrupt when they match. It stores three alarm values: a minute and an hour in packed BCD, and a mask with one bit per weekday. A match needs the minute and the hour to be equal, and the current weekday to be a day whose mask bit is set. Seconds play no part. The block only compares at the moment a new minute begins, which is second zero of that minute. Because the weekday is picked from a mask and not from a date, no alarm can lie further ahead than one week.

The calendar counter elsewhere in the chip supplies the live minute, hour and weekday code, plus a one-cycle strobe at each minute rollover. Software writes the alarm values and an enable bit through a simple write port. Software reads the interrupt and clears the pending event with a one-cycle clear pulse.

A match sets a sticky flag, but only while the alarm is enabled. The interrupt line is the flag gated by the enable. Turning the enable off silences the line and leaves the stored alarm and any pending flag untouched.

Top module: `walarm`

## Requirements
- R1: After reset the flag, the interrupt, the enable, both alarm time registers and the weekday mask are all zero.
- R2: A write with `wrEn` high stores `wrData` in the register chosen by `wrSel`. The codes are: 0 = alarm minute (packed BCD, all 8 bits), 1 = alarm hour (packed BCD, all 8 bits), 2 = weekday mask (bits 6:0, bit n selects weekday code n), 3 = control (bit 0 = enable). The new value governs comparisons from the next cycle onward. A tick in the same cycle as the write still uses the old value.
- R3: A cycle with `minuteTick` high matches when `curMin` equals the alarm minute, `curHour` equals the alarm hour, and the mask bit at index `curWday` is set. If the alarm is enabled, the flag is set at the end of that cycle. If any one of the three parts differs, there is no match.
- R4: Without `minuteTick`, equal time values never set the flag.
- R5: When several mask bits are set, the alarm fires on every selected weekday and on no other weekday.
- R6: A weekday code of 7 never matches. An all-zero mask never matches.
- R7: Once set, the flag stays set until a `clrFlag` pulse, which clears it at the end of that cycle. If a clear and an enabled match occur in the same cycle, the flag ends set.
- R8: While the enable bit is 0, a matching tick does not set the flag, and `alarmIrq` is 0 even if the flag is set. `alarmIrq` equals the flag while the enable bit is 1.
- R9: Clearing the enable bit keeps the stored alarm values and any pending flag. After the enable is set again, a pending flag drives `alarmIrq` at once, and the old alarm fires without being written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 minute, 1 hour, 2 weekday mask, 3 control |
| wrData | input | 8 | Write data |
| clrFlag | input | 1 | One-cycle pulse that clears the sticky flag |
| minuteTick | input | 1 | One-cycle strobe at each new minute from the calendar |
| curMin | input | 8 | Live minute, packed BCD |
| curHour | input | 8 | Live hour, packed BCD |
| curWday | input | 3 | Live weekday code, 0 to 6 |
| alarmFlag | output | 1 | Sticky alarm event flag |
| alarmIrq | output | 1 | Alarm interrupt (flag gated by enable) |

## Verification
Each write, tick or clear is registered on the clock edge that ends its cycle. The flag and interrupt therefore show the result one edge after the stimulus. A change of the enable bit reaches `alarmIrq` at that same edge, because the interrupt is only a gate after the registers. The bench drives every input on the falling edge, holds it for exactly one cycle, and samples on the next falling edge, which is half a cycle after the edge that applied the stimulus. The write-versus-tick ordering case puts both in one cycle to confirm that the old minute value is the one compared.

// File: rtl/walarm_pkg.sv
package walarm_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_MIN  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_HOUR = 2'd1;
  localparam logic [SEL_W-1:0] SEL_MASK = 2'd2;
  localparam logic [SEL_W-1:0] SEL_CTRL = 2'd3;

  // load strobes from control to datapath
  typedef struct packed {
    logic ldMin;
    logic ldHour;
    logic ldMask;
  } dpStrobe_t;
endpackage

// File: rtl/walarm_dp.sv
module walarm_dp
  import walarm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DAY_N  = 7,
  localparam int DAY_W = $clog2(DAY_N + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] curMin,
  input  logic [DATA_W-1:0] curHour,
  input  logic [DAY_W-1:0]  curWday,
  output logic              matchHit
);
  logic [DATA_W-1:0] almMin;
  logic [DATA_W-1:0] almHour;
  logic [DAY_N-1:0]  dayMask;
  logic [DAY_N-1:0]  dayHit;
  logic              minEq;
  logic              hourEq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      almMin  <= '0;
      almHour <= '0;
      dayMask <= '0;
    end else begin
      if (strobe.ldMin)  almMin  <= wrData;
      if (strobe.ldHour) almHour <= wrData;
      if (strobe.ldMask) dayMask <= wrData[DAY_N-1:0];
    end
  end

  // one comparator per weekday; codes outside 0..DAY_N-1 hit nothing
  for (genvar d = 0; d < DAY_N; d++) begin : g_day
    assign dayHit[d] = dayMask[d] && (curWday == DAY_W'(d));
  end

  assign minEq    = (curMin == almMin);
  assign hourEq   = (curHour == almHour);
  assign matchHit = minEq && hourEq && (|dayHit);
endmodule

// File: rtl/walarm_ctrl.sv
module walarm_ctrl
  import walarm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic             wrEnBit,
  input  logic             clrFlag,
  input  logic             minuteTick,
  input  logic             matchHit,
  output dpStrobe_t        strobe,
  output logic             alarmEn,
  output logic             flagQ
);
  logic ctrlLd;
  logic fireNow;

  always_comb begin
    strobe.ldMin  = wrEn && (wrSel == SEL_MIN);
    strobe.ldHour = wrEn && (wrSel == SEL_HOUR);
    strobe.ldMask = wrEn && (wrSel == SEL_MASK);
    ctrlLd        = wrEn && (wrSel == SEL_CTRL);
  end

  assign fireNow = minuteTick && alarmEn && matchHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarmEn <= 1'b0;
      flagQ   <= 1'b0;
    end else begin
      if (ctrlLd) alarmEn <= wrEnBit;
      // a fresh event outranks a clear in the same cycle
      if (fireNow)      flagQ <= 1'b1;
      else if (clrFlag) flagQ <= 1'b0;
    end
  end
endmodule

// File: rtl/walarm.sv
module walarm
  import walarm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DAY_N  = 7,
  localparam int DAY_W = $clog2(DAY_N + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              clrFlag,
  input  logic              minuteTick,
  input  logic [DATA_W-1:0] curMin,
  input  logic [DATA_W-1:0] curHour,
  input  logic [DAY_W-1:0]  curWday,
  output logic              alarmFlag,
  output logic              alarmIrq
);
  dpStrobe_t strobe;
  logic      matchHit;
  logic      alarmEn;
  logic      flagQ;

  walarm_ctrl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .wrEnBit    (wrData[0]),
    .clrFlag    (clrFlag),
    .minuteTick (minuteTick),
    .matchHit   (matchHit),
    .strobe     (strobe),
    .alarmEn    (alarmEn),
    .flagQ      (flagQ)
  );

  walarm_dp #(.DATA_W(DATA_W), .DAY_N(DAY_N)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .curMin   (curMin),
    .curHour  (curHour),
    .curWday  (curWday),
    .matchHit (matchHit)
  );

  assign alarmFlag = flagQ;
  assign alarmIrq  = flagQ && alarmEn;
endmodule

// File: rtl/walarm_chk.sv
module walarm_chk #(
  parameter int DAY_N = 7,
  localparam int DAY_W = $clog2(DAY_N + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             minuteTick,
  input logic             clrFlag,
  input logic             matchHit,
  input logic             alarmEn,
  input logic [DAY_W-1:0] curWday,
  input logic             alarmFlag,
  input logic             alarmIrq
);
  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    minuteTick && alarmEn && matchHit |=> alarmFlag);

  // R7
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrFlag && !(minuteTick && alarmEn && matchHit) |=> !alarmFlag);

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarmFlag && !clrFlag |=> alarmFlag);

  // R4
  no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !alarmFlag && !minuteTick |=> !alarmFlag);

  // R8
  no_fire_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !alarmFlag && !alarmEn |=> !alarmFlag);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> alarmFlag && alarmEn);

  // R6
  bad_day_chk: assert property (@(posedge clk) disable iff (!rstN)
    curWday >= DAY_W'(DAY_N) |-> !matchHit);
endmodule

bind walarm walarm_chk #(.DAY_N(DAY_N)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .minuteTick (minuteTick),
  .clrFlag    (clrFlag),
  .matchHit   (matchHit),
  .alarmEn    (alarmEn),
  .curWday    (curWday),
  .alarmFlag  (alarmFlag),
  .alarmIrq   (alarmIrq)
);

// File: tb/sim_walarm.sv
module sim_walarm;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [7:0] wrData = '0;
  logic       clrFlag = 1'b0;
  logic       minuteTick = 1'b0;
  logic [7:0] curMin = '0;
  logic [7:0] curHour = '0;
  logic [2:0] curWday = '0;
  logic       alarmFlag;
  logic       alarmIrq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  walarm u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .clrFlag(clrFlag), .minuteTick(minuteTick), .curMin(curMin),
    .curHour(curHour), .curWday(curWday), .alarmFlag(alarmFlag),
    .alarmIrq(alarmIrq)
  );

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {flag,irq} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic checkOut(input string tag, input logic eFlag, input logic eIrq);
    check(tag, {alarmFlag, alarmIrq}, {eFlag, eIrq});
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tickAt(input logic [7:0] m, input logic [7:0] h, input logic [2:0] wd);
    @(negedge clk);
    curMin = m; curHour = h; curWday = wd; minuteTick = 1'b1;
    @(negedge clk);
    minuteTick = 1'b0;
  endtask

  task automatic pulseClr();
    @(negedge clk);
    clrFlag = 1'b1;
    @(negedge clk);
    clrFlag = 1'b0;
  endtask

  task automatic tResetState();
    checkOut("R1 reset outputs", 1'b0, 1'b0);
    writeReg(2'd3, 8'h01);
    tickAt(8'h00, 8'h00, 3'd0);
    checkOut("R1 reset mask/time zero, no match", 1'b0, 1'b0);
  endtask

  task automatic tBasicMatch();
    writeReg(2'd0, 8'h30);
    writeReg(2'd1, 8'h12);
    writeReg(2'd2, 8'h08);
    tickAt(8'h30, 8'h12, 3'd3);
    checkOut("R3 R2 full match fires", 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    checkOut("R7 flag sticky", 1'b1, 1'b1);
    pulseClr();
    checkOut("R7 clear drops flag", 1'b0, 1'b0);
  endtask

  task automatic tMismatch();
    tickAt(8'h31, 8'h12, 3'd3);
    checkOut("R3 minute differs", 1'b0, 1'b0);
    tickAt(8'h30, 8'h13, 3'd3);
    checkOut("R3 hour differs", 1'b0, 1'b0);
    tickAt(8'h30, 8'h12, 3'd4);
    checkOut("R3 weekday not in mask", 1'b0, 1'b0);
  endtask

  task automatic tNoTick();
    @(negedge clk);
    curMin = 8'h30; curHour = 8'h12; curWday = 3'd3;
    repeat (4) @(negedge clk);
    checkOut("R4 equal values without tick", 1'b0, 1'b0);
  endtask

  task automatic tMultiDay();
    writeReg(2'd2, 8'h41);
    tickAt(8'h30, 8'h12, 3'd0);
    checkOut("R5 fires on day 0", 1'b1, 1'b1);
    pulseClr();
    tickAt(8'h30, 8'h12, 3'd6);
    checkOut("R5 fires on day 6", 1'b1, 1'b1);
    pulseClr();
    tickAt(8'h30, 8'h12, 3'd3);
    checkOut("R5 silent on unselected day", 1'b0, 1'b0);
    writeReg(2'd2, 8'h7F);
    tickAt(8'h30, 8'h12, 3'd7);
    checkOut("R6 weekday code 7 never matches", 1'b0, 1'b0);
    writeReg(2'd2, 8'h00);
    tickAt(8'h30, 8'h12, 3'd2);
    checkOut("R6 empty mask never matches", 1'b0, 1'b0);
    writeReg(2'd2, 8'h08);
  endtask

  task automatic tEnable();
    writeReg(2'd3, 8'h00);
    tickAt(8'h30, 8'h12, 3'd3);
    checkOut("R8 disabled match ignored", 1'b0, 1'b0);
    writeReg(2'd3, 8'h01);
    checkOut("R8 enabling alone raises nothing", 1'b0, 1'b0);
    tickAt(8'h30, 8'h12, 3'd3);
    checkOut("R9 values kept across disable", 1'b1, 1'b1);
    writeReg(2'd3, 8'h00);
    checkOut("R8 disable gates irq, flag kept", 1'b1, 1'b0);
    writeReg(2'd3, 8'h01);
    checkOut("R9 re-enable shows pending flag", 1'b1, 1'b1);
    pulseClr();
  endtask

  task automatic tClearRace();
    @(negedge clk);
    curMin = 8'h30; curHour = 8'h12; curWday = 3'd3;
    minuteTick = 1'b1; clrFlag = 1'b1;
    @(negedge clk);
    minuteTick = 1'b0; clrFlag = 1'b0;
    checkOut("R7 match beats same-cycle clear", 1'b1, 1'b1);
    pulseClr();
    checkOut("R7 cleared after race", 1'b0, 1'b0);
  endtask

  task automatic tWriteOrder();
    // new minute written in the same cycle as a tick carrying that minute
    @(negedge clk);
    wrEn = 1'b1; wrSel = 2'd0; wrData = 8'h45;
    curMin = 8'h45; curHour = 8'h12; curWday = 3'd3; minuteTick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; minuteTick = 1'b0;
    checkOut("R2 same-cycle write uses old minute", 1'b0, 1'b0);
    tickAt(8'h45, 8'h12, 3'd3);
    checkOut("R2 written minute active next cycle", 1'b1, 1'b1);
    pulseClr();
    tickAt(8'h30, 8'h12, 3'd3);
    checkOut("R2 old minute replaced", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tBasicMatch();
    tMismatch();
    tNoTick();
    tMultiDay();
    tEnable();
    tClearRace();
    tWriteOrder();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule